// File: doc/BRIEF.md
# Serial Bit Clock Generator

This block produces the bit clock for a serial port by dividing a chosen tick source by a programmable divisor. Two tick sources are available. The first is a fixed prescaler that gives one tick every four system clocks. The second is an external clock level that is synchronised into the system domain, with one tick on each rising edge. A source-select pin chooses between them. An 8-bit divisor sets the length of each output period in ticks. The high and low phases of the output are then set by an odd/even rule.

Every output period starts with its low phase and ends with its high phase. The block drives the clock level and two one-cycle strobes. The strobes mark the cycle in which the level rises and the cycle in which it falls. A logic above the block can use the strobes to shift or sample data without detecting edges again. A run enable lets the logic above stop the clock between words. While the enable is low, the output stays low and all counting state is cleared. A divisor written while the clock runs is picked up only when the next period starts.

The block has no data stream, so all of its pins are plain control and status signals with no handshake.

Top module: `sclk_gen`

## Requirements
- R1: While reset is asserted and after it is released with the run enable low, `bclk`, `bclk_rise` and `bclk_fall` are all 0.
- R2: The output level changes only on a tick. A full period lasts 1+`divisor` ticks when `divisor` is 1 or more, and lasts 2 ticks when `divisor` is 0.
- R3: For an even nonzero `divisor` d, the high phase lasts d/2+1 ticks and the low phase lasts d/2 ticks.
- R4: For an odd `divisor` d, both phases last (d+1)/2 ticks. For `divisor` 0, both phases last 1 tick.
- R5: With `src_sel` = 1, ticks come from the internal prescaler, one tick every 4 system clocks. A phase of n ticks therefore lasts 4n system clocks.
- R6: With `src_sel` = 0, a tick occurs once for each rising edge of `ext_clk`, after a two-flop synchroniser. While `ext_clk` is held still, the output does not change.
- R7: While `run_en` is 0, `bclk` is low one cycle later and no rise strobe occurs. All counters are cleared. With `src_sel` = 1, `bclk` first rises on the (4L−1)-th rising clock edge after the first edge that samples `run_en` high, where L is the low width.
- R8: A new `divisor` value leaves the phase in progress unchanged and takes effect at the start of the next low phase.
- R9: `bclk_rise` is 1 for exactly the cycle in which `bclk` goes from 0 to 1. `bclk_fall` is 1 for exactly the cycle in which `bclk` goes from 1 to 0, including a fall forced by `run_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Clock run enable; when low, the output is held low and counting is cleared |
| src_sel | input | 1 | Tick source: 1 = system clock divided by 4, 0 = external clock |
| ext_clk | input | 1 | External clock level, asynchronous to `clk` |
| divisor | input | 8 | Period divisor d |
| bclk | output | 1 | Divided bit clock level |
| bclk_rise | output | 1 | One-cycle strobe on each rise of `bclk` |
| bclk_fall | output | 1 | One-cycle strobe on each fall of `bclk` |

## Verification
The bench sweeps the divisor through its low range and its top end, and measures the first low phase, the high phase, the next low phase and the full period each time. Divisor 0 is the case most likely to break. A design that applied the plain halving rule there would build a zero-length phase and either stall or toggle on every tick. A design that swapped the phase rule would give the extra tick to the low phase for even divisors, and the high and low run lengths would show it. The bench also changes the divisor in the middle of a high phase, where a design that reloaded at once would cut that phase short. Disabling while the output is high tests that the level drops and that a fall strobe comes out. Restarting tests that the first low phase is a full fresh one and not a leftover count.

// File: rtl/sclk_gen_pkg.sv
package sclk_gen_pkg;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;

  typedef enum logic {
    SRC_EXT = 1'b0,
    SRC_INT = 1'b1
  } src_e;

endpackage

// File: rtl/sclk_tick_src.sv
module sclk_tick_src #(
  parameter int PRESCALE    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic src_sel,
  input  logic ext_clk,
  output logic tick
);
  import sclk_gen_pkg::*;

  localparam int PRE_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0]       pre_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   ext_prev_q;
  logic                   tick_int;
  logic                   tick_ext;

  // internal prescaler, cleared while stopped so each start is aligned
  always_ff @(posedge clk) begin
    if (!rst_n || !run_en) begin
      pre_q <= '0;
    end else if (pre_q == PRE_LAST) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  // synchroniser chain for the external clock level
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= ext_clk;
      end
    end else begin : g_syncn
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], ext_clk};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) ext_prev_q <= 1'b0;
    else        ext_prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign tick_int = (pre_q == PRE_LAST);
  assign tick_ext = sync_q[SYNC_STAGES-1] && !ext_prev_q;

  always_comb begin
    if (!run_en)                 tick = 1'b0;
    else if (src_sel == SRC_INT) tick = tick_int;
    else                         tick = tick_ext;
  end

endmodule

// File: rtl/sclk_width_calc.sv
module sclk_width_calc #(
  parameter int DIV_W = 8
) (
  input  logic [DIV_W-1:0] div,
  output logic [DIV_W-1:0] lo_w,
  output logic [DIV_W-1:0] hi_w
);
  logic [DIV_W:0] half_up;
  logic [DIV_W:0] half_dn;

  assign half_up = ({1'b0, div} + 1'b1) >> 1;
  assign half_dn = {1'b0, div} >> 1;

  always_comb begin
    if (div == '0) begin
      lo_w = DIV_W'(1);
      hi_w = DIV_W'(1);
    end else if (div[0]) begin
      lo_w = half_up[DIV_W-1:0];
      hi_w = half_up[DIV_W-1:0];
    end else begin
      lo_w = half_dn[DIV_W-1:0];
      hi_w = half_dn[DIV_W-1:0] + 1'b1;
    end
  end

endmodule

// File: rtl/sclk_phase_div.sv
module sclk_phase_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             tick,
  input  logic [DIV_W-1:0] lo_new,
  input  logic [DIV_W-1:0] hi_new,
  output logic             level,
  output logic             rise,
  output logic             fall
);
  import sclk_gen_pkg::*;

  phase_e           phase_q;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lo_q;
  logic [DIV_W-1:0] hi_q;
  logic             rise_q;
  logic             fall_q;
  logic             lo_done;
  logic             hi_done;

  assign lo_done = (cnt_q == lo_q - 1'b1);
  assign hi_done = (cnt_q == hi_q - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_LOW;
      cnt_q   <= '0;
      lo_q    <= DIV_W'(1);
      hi_q    <= DIV_W'(1);
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
    end else begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      if (!run_en) begin
        fall_q  <= (phase_q == PH_HIGH);
        phase_q <= PH_LOW;
        cnt_q   <= '0;
        lo_q    <= lo_new;
        hi_q    <= hi_new;
      end else if (tick) begin
        if (phase_q == PH_LOW) begin
          if (lo_done) begin
            phase_q <= PH_HIGH;
            cnt_q   <= '0;
            rise_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else begin
          if (hi_done) begin
            phase_q <= PH_LOW;
            cnt_q   <= '0;
            fall_q  <= 1'b1;
            lo_q    <= lo_new;
            hi_q    <= hi_new;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

  assign level = (phase_q == PH_HIGH);
  assign rise  = rise_q;
  assign fall  = fall_q;

endmodule

// File: rtl/sclk_gen.sv
module sclk_gen #(
  parameter int DIV_W       = 8,
  parameter int PRESCALE    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             src_sel,
  input  logic             ext_clk,
  input  logic [DIV_W-1:0] divisor,
  output logic             bclk,
  output logic             bclk_rise,
  output logic             bclk_fall
);
  logic             tick_w;
  logic [DIV_W-1:0] lo_w;
  logic [DIV_W-1:0] hi_w;

  sclk_tick_src #(
    .PRESCALE   (PRESCALE),
    .SYNC_STAGES(SYNC_STAGES)
  ) tick_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_en (run_en),
    .src_sel(src_sel),
    .ext_clk(ext_clk),
    .tick   (tick_w)
  );

  sclk_width_calc #(.DIV_W(DIV_W)) width_i (
    .div (divisor),
    .lo_w(lo_w),
    .hi_w(hi_w)
  );

  sclk_phase_div #(.DIV_W(DIV_W)) div_i (
    .clk   (clk),
    .rst_n (rst_n),
    .run_en(run_en),
    .tick  (tick_w),
    .lo_new(lo_w),
    .hi_new(hi_w),
    .level (bclk),
    .rise  (bclk_rise),
    .fall  (bclk_fall)
  );

endmodule

// File: rtl/sclk_gen_chk.sv
module sclk_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic run_en,
  input logic tick,
  input logic bclk,
  input logic bclk_rise,
  input logic bclk_fall
);

  // R9: rise strobe marks exactly the 0->1 cycle
  p_rise_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_rise == (bclk && !$past(bclk)));

  // R9: fall strobe marks exactly the 1->0 cycle
  p_fall_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_fall == (!bclk && $past(bclk)));

  // R7: stopped clock is low and never rises
  p_hold_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!bclk && !bclk_rise));

  // R2: level changes only on a tick while running
  p_only_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !tick) |=> $stable(bclk));

  // R5: every rise follows a tick
  p_rise_needs_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_rise |-> $past(tick));

endmodule

bind sclk_gen sclk_gen_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .run_en   (run_en),
  .tick     (tick_w),
  .bclk     (bclk),
  .bclk_rise(bclk_rise),
  .bclk_fall(bclk_fall)
);

// File: tb/sclk_gen_tb_top.sv
`timescale 1ns/1ps
module sclk_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run_en = 1'b0;
  logic       src_sel = 1'b1;
  logic       ext_clk = 1'b0;
  logic [7:0] divisor = 8'd0;
  logic       bclk, bclk_rise, bclk_fall;

  int  total = 0;
  int  bad = 0;
  int  strobe_err = 0;
  bit  done = 0;
  bit  ext_run = 0;
  logic prev_bclk = 1'b0;

  always #2 clk = ~clk;

  sclk_gen dut_i (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .src_sel(src_sel),
    .ext_clk(ext_clk), .divisor(divisor),
    .bclk(bclk), .bclk_rise(bclk_rise), .bclk_fall(bclk_fall)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R9 strobe monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (bclk_rise !== (bclk && !prev_bclk)) strobe_err++;
      if (bclk_fall !== (!bclk && prev_bclk)) strobe_err++;
    end
    prev_bclk = bclk;
  end

  // external clock: toggles every 3 cycles -> one rising edge per 6 cycles
  int ext_cnt = 0;
  always @(negedge clk) begin
    if (ext_run) begin
      ext_cnt++;
      if (ext_cnt == 3) begin
        ext_cnt = 0;
        ext_clk = ~ext_clk;
      end
    end
  end

  task automatic run_len(input logic v, output int n);
    n = 0;
    while (bclk === v && n < 20000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic sync_to_rise();
    int guard = 0;
    while (!(bclk === 1'b1 && bclk_rise === 1'b1) && guard < 20000) begin
      guard++;
      @(negedge clk);
    end
  endtask

  function automatic int lo_of(input int d);
    if (d == 0) return 1;
    if (d % 2 == 1) return (d + 1) / 2;
    return d / 2;
  endfunction

  function automatic int hi_of(input int d);
    if (d == 0) return 1;
    if (d % 2 == 1) return (d + 1) / 2;
    return d / 2 + 1;
  endfunction

  task automatic measure_int(input int d);
    int first_lo, h1, l1, h2, per, lw, hw;
    lw = lo_of(d);
    hw = hi_of(d);
    per = (d == 0) ? 2 : d + 1;
    run_en = 1'b0; src_sel = 1'b1; divisor = 8'(d);
    @(negedge clk); @(negedge clk);
    check("R7 held low", int'(bclk), 0);
    run_en = 1'b1;
    @(negedge clk);
    run_len(1'b0, first_lo);
    check("R7 first low", first_lo, 4*lw - 1);
    run_len(1'b1, h1);
    run_len(1'b0, l1);
    run_len(1'b1, h2);
    if (d == 0 || d % 2 == 1) begin
      check("R4 high", h1, 4*hw);
      check("R4 low", l1, 4*lw);
    end else begin
      check("R3 high", h1, 4*hw);
      check("R3 low", l1, 4*lw);
    end
    check("R2 R5 period", h2 + l1, 4*per);
  endtask

  initial begin
    int h, l;
    repeat (3) @(negedge clk);
    check("R1 reset bclk", int'(bclk), 0);
    check("R1 reset strobes", int'(bclk_rise | bclk_fall), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 idle after reset", int'(bclk | bclk_rise | bclk_fall), 0);

    for (int d = 0; d <= 40; d++) measure_int(d);
    for (int d = 250; d <= 255; d++) measure_int(d);

    // R8: divisor change during a high phase
    run_en = 1'b0; divisor = 8'd2;
    @(negedge clk);
    run_en = 1'b1;
    sync_to_rise();
    divisor = 8'd5;
    run_len(1'b1, h);
    check("R8 current high kept", h, 8);
    run_len(1'b0, l);
    check("R8 next low new", l, 12);
    run_len(1'b1, h);
    check("R8 next high new", h, 12);

    // R7: disable while high
    divisor = 8'd6;
    sync_to_rise();
    run_en = 1'b0;
    @(negedge clk);
    check("R7 drop on disable", int'(bclk), 0);
    check("R9 fall on disable", int'(bclk_fall), 1);
    h = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (bclk !== 1'b0 || bclk_rise !== 1'b0) h++;
    end
    check("R7 stays low", h, 0);

    // R6: external source
    src_sel = 1'b0; divisor = 8'd3;
    ext_run = 1;
    @(negedge clk);
    run_en = 1'b1;
    sync_to_rise();
    run_len(1'b1, h);
    run_len(1'b0, l);
    check("R6 ext high d3", h, 12);
    check("R6 ext low d3", l, 12);
    run_en = 1'b0; divisor = 8'd4;
    @(negedge clk);
    run_en = 1'b1;
    sync_to_rise();
    run_len(1'b1, h);
    run_len(1'b0, l);
    check("R6 ext high d4", h, 18);
    check("R6 ext low d4", l, 12);
    ext_run = 0;
    h = 0;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (bclk_rise === 1'b1 || bclk_fall === 1'b1) h++;
    end
    check("R6 no edges with ext still", h, 0);

    check("R9 strobe mismatches", strobe_err, 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule